// File: doc/BRIEF.md
# Grouped Tributary Output Selector Bank

This block drives the first-order tributary outputs of a demultiplexer. It holds 28 lanes, arranged as 7 groups of 4 neighbouring lanes. Each lane receives demultiplexed serial data together with its own tributary clock. The lane retimes that data onto its output on the tributary clock edge chosen for it. When the lane's alarm bit is set, or when a failure is reported at either of the two higher multiplex levels above it, the lane sends all ones instead of the data.

A type bit for each group sets the group to one of two payload kinds. When the bit is 1, the group carries the lower-rate kind and all four lanes are active. When the bit is 0, the group carries the higher-rate kind, only three lanes are needed, and the last lane of the group is forced to zero.

All logic runs on one system clock. Each tributary clock and its data pass through a short synchronizer, and an edge detector picks out the edge selected for that lane. Every lane also has a 2-bit select field, which the block passes straight through to its output.

Top module: `trib_sel_bank`

## Requirements
- R1: While reset is asserted, and after reset until the first selected tributary clock edge, every `outData` bit is 0.
- R2: When `edgeRise[c]` is 1, lane c loads a new output value only on a rising edge of `tribClk[c]`. Its output does not change on a falling edge.
- R3: When `edgeRise[c]` is 0, lane c loads a new output value only on a falling edge of `tribClk[c]`. Its output does not change on a rising edge.
- R4: On a selected edge, lane c loads `tribData[c]` when `aisEn[c]` is 0, and loads 1 when `aisEn[c]` is 1.
- R5: When `groupFail[g]` is 1 on a selected edge of a lane in group g (lanes 4g to 4g+3, counted from 0), that lane loads 1. Lanes of other groups are not affected.
- R6: When `globalFail` is 1 on a selected edge of any lane, that lane loads 1.
- R7: When `groupDs1[g]` is 0, lane 4g+3 (the last lane of group g) outputs 0 at all times. This takes priority over `aisEn`, `groupFail` and `globalFail`. The other three lanes of the group work normally.
- R8: When `groupDs1[g]` is 1, all four lanes of group g, including lane 4g+3, output their loaded values.
- R9: `outSel[2c+1:2c]` always equals `chanSel[2c+1:2c]`, in the same cycle, for every lane c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the tributary clocks |
| rstN | input | 1 | Active-low synchronous reset |
| tribClk | input | 28 | Tributary clock, one bit per lane |
| tribData | input | 28 | Demultiplexed data, one bit per lane |
| edgeRise | input | 28 | Edge select per lane: 1 = rising edge, 0 = falling edge |
| aisEn | input | 28 | Per-lane all-ones alarm request |
| groupDs1 | input | 7 | Per-group type: 1 = four active lanes, 0 = three active lanes |
| groupFail | input | 7 | Per-group failure from the level above, forces all ones |
| globalFail | input | 1 | Failure from the top level, forces all ones on every lane |
| chanSel | input | 56 | Per-lane 2-bit select field, 2 bits per lane |
| outSel | output | 56 | The select field, passed through unchanged |
| outData | output | 28 | Retimed tributary output, one bit per lane |

## Verification
The hardest case to reach is a lane that holds a stale value while other lanes update. This happens when a lane's edge select points to the half-period that has not yet occurred, or when a masked last lane keeps a loaded value that appears only once its group changes back to four-lane mode. To reach it, the stimulus drives all tributary clocks together through a rising half-period and then a falling half-period, and checks every lane after each half. Edge selects, group types and alarm sources are randomized between cycles, so lanes in both edge modes and both group modes sit side by side. Directed cases add a masked lane that has both an alarm and a group failure, and a failure confined to a single group.

// File: rtl/trib_sel_pkg.sv
package trib_sel_pkg;

  // Per-lane control strobes handed from control to datapath
  typedef struct packed {
    logic forceLow;   // lane is the unused slot of a three-lane group
    logic forceOnes;  // load all ones at the next selected edge
  } laneCtrl_t;

endpackage

// File: rtl/trib_sel_ctrl.sv
module trib_sel_ctrl
  import trib_sel_pkg::*;
#(
  parameter int NUM_GROUPS   = 7,
  parameter int CH_PER_GROUP = 4,
  localparam int NUM_CH      = NUM_GROUPS * CH_PER_GROUP
) (
  input  logic [NUM_GROUPS-1:0] groupDs1,
  input  logic [NUM_GROUPS-1:0] groupFail,
  input  logic                  globalFail,
  input  logic [NUM_CH-1:0]     aisEn,
  output laneCtrl_t [NUM_CH-1:0] laneCtrl
);

  localparam int SPARE_LANE = CH_PER_GROUP - 1;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar k = 0; k < CH_PER_GROUP; k++) begin : g_lane
      localparam int IDX = g * CH_PER_GROUP + k;
      if (k == SPARE_LANE) begin : g_spare
        assign laneCtrl[IDX].forceLow = ~groupDs1[g];
      end else begin : g_active
        assign laneCtrl[IDX].forceLow = 1'b0;
      end
      assign laneCtrl[IDX].forceOnes = aisEn[IDX] | groupFail[g] | globalFail;
    end
  end

endmodule

// File: rtl/trib_sel_lane.sv
module trib_sel_lane
  import trib_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tribClk,
  input  logic      tribData,
  input  logic      edgeRise,
  input  laneCtrl_t ctrl,
  output logic      capStb,
  output logic      dataOut
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] clkPipe;
  logic [SYNC_STAGES-1:0] dataPipe;
  logic                   clkLast;
  logic                   held;
  logic                   riseSeen;
  logic                   fallSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkPipe  <= '0;
      dataPipe <= '0;
      clkLast  <= 1'b0;
      held     <= 1'b0;
    end else begin
      clkPipe  <= {clkPipe[LAST-1:0], tribClk};
      dataPipe <= {dataPipe[LAST-1:0], tribData};
      clkLast  <= clkPipe[LAST];
      if (capStb) held <= ctrl.forceOnes | dataPipe[LAST];
    end
  end

  assign riseSeen = clkPipe[LAST] & ~clkLast;
  assign fallSeen = ~clkPipe[LAST] & clkLast;
  assign capStb   = edgeRise ? riseSeen : fallSeen;
  assign dataOut  = held & ~ctrl.forceLow;

endmodule

// File: rtl/trib_sel_datapath.sv
module trib_sel_datapath
  import trib_sel_pkg::*;
#(
  parameter int NUM_CH      = 28,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_CH-1:0]      tribClk,
  input  logic [NUM_CH-1:0]      tribData,
  input  logic [NUM_CH-1:0]      edgeRise,
  input  laneCtrl_t [NUM_CH-1:0] laneCtrl,
  output logic [NUM_CH-1:0]      capStb,
  output logic [NUM_CH-1:0]      outData
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    trib_sel_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .tribClk  (tribClk[c]),
      .tribData (tribData[c]),
      .edgeRise (edgeRise[c]),
      .ctrl     (laneCtrl[c]),
      .capStb   (capStb[c]),
      .dataOut  (outData[c])
    );
  end

endmodule

// File: rtl/trib_sel_bank.sv
module trib_sel_bank
  import trib_sel_pkg::*;
#(
  parameter int NUM_GROUPS   = 7,
  parameter int CH_PER_GROUP = 4,
  parameter int SEL_W        = 2,
  parameter int SYNC_STAGES  = 2,
  localparam int NUM_CH      = NUM_GROUPS * CH_PER_GROUP
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       tribClk,
  input  logic [NUM_CH-1:0]       tribData,
  input  logic [NUM_CH-1:0]       edgeRise,
  input  logic [NUM_CH-1:0]       aisEn,
  input  logic [NUM_GROUPS-1:0]   groupDs1,
  input  logic [NUM_GROUPS-1:0]   groupFail,
  input  logic                    globalFail,
  input  logic [NUM_CH*SEL_W-1:0] chanSel,
  output logic [NUM_CH*SEL_W-1:0] outSel,
  output logic [NUM_CH-1:0]       outData
);

  laneCtrl_t [NUM_CH-1:0] laneCtrl;
  logic [NUM_CH-1:0]      capStb;

  trib_sel_ctrl #(
    .NUM_GROUPS   (NUM_GROUPS),
    .CH_PER_GROUP (CH_PER_GROUP)
  ) u_ctrl (
    .groupDs1   (groupDs1),
    .groupFail  (groupFail),
    .globalFail (globalFail),
    .aisEn      (aisEn),
    .laneCtrl   (laneCtrl)
  );

  trib_sel_datapath #(
    .NUM_CH      (NUM_CH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tribClk  (tribClk),
    .tribData (tribData),
    .edgeRise (edgeRise),
    .laneCtrl (laneCtrl),
    .capStb   (capStb),
    .outData  (outData)
  );

  assign outSel = chanSel;

endmodule

// File: rtl/trib_sel_chk.sv
module trib_sel_chk #(
  parameter int NUM_GROUPS   = 7,
  parameter int CH_PER_GROUP = 4,
  parameter int SEL_W        = 2,
  localparam int NUM_CH      = NUM_GROUPS * CH_PER_GROUP
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_CH-1:0]       aisEn,
  input logic [NUM_GROUPS-1:0]   groupDs1,
  input logic [NUM_GROUPS-1:0]   groupFail,
  input logic                    globalFail,
  input logic [NUM_CH*SEL_W-1:0] chanSel,
  input logic [NUM_CH*SEL_W-1:0] outSel,
  input logic [NUM_CH-1:0]       outData,
  input logic [NUM_CH-1:0]       capStb
);

  AST_SEL_PASS: assert property (@(posedge clk) disable iff (!rstN)
    outSel == chanSel); // R9

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar k = 0; k < CH_PER_GROUP; k++) begin : g_lane
      localparam int IDX = g * CH_PER_GROUP + k;
      if (k == CH_PER_GROUP - 1) begin : g_spare
        AST_SPARE_LOW: assert property (@(posedge clk) disable iff (!rstN)
          !groupDs1[g] |-> !outData[IDX]); // R7
      end else begin : g_active
        AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rstN)
          !capStb[IDX] |=> $stable(outData[IDX])); // R2
        AST_AIS_ONES: assert property (@(posedge clk) disable iff (!rstN)
          capStb[IDX] && aisEn[IDX] |=> outData[IDX]); // R4
        AST_GROUP_ONES: assert property (@(posedge clk) disable iff (!rstN)
          capStb[IDX] && groupFail[g] |=> outData[IDX]); // R5
        AST_GLOBAL_ONES: assert property (@(posedge clk) disable iff (!rstN)
          capStb[IDX] && globalFail |=> outData[IDX]); // R6
      end
    end
  end

endmodule

bind trib_sel_bank trib_sel_chk #(
  .NUM_GROUPS   (NUM_GROUPS),
  .CH_PER_GROUP (CH_PER_GROUP),
  .SEL_W        (SEL_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .aisEn      (aisEn),
  .groupDs1   (groupDs1),
  .groupFail  (groupFail),
  .globalFail (globalFail),
  .chanSel    (chanSel),
  .outSel     (outSel),
  .outData    (outData),
  .capStb     (capStb)
);

// File: tb/sim_trib_sel_bank.sv
`timescale 1ns/1ps
module sim_trib_sel_bank;

  localparam int NG   = 7;
  localparam int CPG  = 4;
  localparam int NCH  = NG * CPG;
  localparam int SELW = 2;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0]      tribClk = '0, tribData = '0, edgeRise = '0, aisEn = '0;
  logic [NG-1:0]       groupDs1 = '1, groupFail = '0;
  logic                globalFail = 1'b0;
  logic [NCH*SELW-1:0] chanSel = '0;
  logic [NCH*SELW-1:0] outSel;
  logic [NCH-1:0]      outData;

  logic [NCH-1:0] expCap = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trib_sel_bank u0 (
    .clk(clk), .rstN(rstN), .tribClk(tribClk), .tribData(tribData),
    .edgeRise(edgeRise), .aisEn(aisEn), .groupDs1(groupDs1),
    .groupFail(groupFail), .globalFail(globalFail), .chanSel(chanSel),
    .outSel(outSel), .outData(outData)
  );

  function automatic logic capVal(int c);
    return (aisEn[c] | groupFail[c / CPG] | globalFail) ? 1'b1 : tribData[c];
  endfunction

  function automatic bit isMasked(int c);
    return (c % CPG == CPG - 1) && !groupDs1[c / CPG];
  endfunction

  function automatic string laneTag(int c);
    if (isMasked(c))          return "R7";
    if (globalFail)           return "R6";
    if (groupFail[c / CPG])   return "R5";
    if (aisEn[c])             return "R4";
    if (c % CPG == CPG - 1)   return "R8";
    return edgeRise[c] ? "R2" : "R3";
  endfunction

  task automatic checkLanes();
    for (int c = 0; c < NCH; c++) begin
      logic expV;
      expV = isMasked(c) ? 1'b0 : expCap[c];
      checks++;
      if (outData[c] !== expV) begin
        errors++;
        $display("FAIL %s lane %0d: outData=%b expected=%b", laneTag(c), c, outData[c], expV);
      end
    end
  endtask

  task automatic checkSel();
    checks++;
    if (outSel !== chanSel) begin
      errors++;
      $display("FAIL R9 outSel=%h expected=%h", outSel, chanSel);
    end
  endtask

  task automatic halfRise();
    @(negedge clk) tribClk = '1;
    repeat (HALF) @(negedge clk);
    for (int c = 0; c < NCH; c++) if (edgeRise[c]) expCap[c] = capVal(c);
    checkLanes();
  endtask

  task automatic halfFall();
    @(negedge clk) tribClk = '0;
    repeat (HALF) @(negedge clk);
    for (int c = 0; c < NCH; c++) if (!edgeRise[c]) expCap[c] = capVal(c);
    checkLanes();
  endtask

  task automatic fullCycle();
    halfRise();
    checkSel();
    halfFall();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    // R1: outputs low during and just after reset, even with alarms pending
    aisEn = '1;
    globalFail = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (outData !== '0) begin
      errors++;
      $display("FAIL R1 in reset outData=%h expected=0", outData);
    end
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    checks++;
    if (outData !== '0) begin
      errors++;
      $display("FAIL R1 after reset outData=%h expected=0", outData);
    end
    aisEn = '0;
    globalFail = 1'b0;

    // Directed: clean data, half the lanes on each edge (R2, R3, R8)
    tribData = NCH'(28'hA5C3_69F);
    edgeRise = NCH'(28'h5555_555);
    chanSel  = {24'hABCDEF, 32'h1357_9BDF};
    fullCycle();
    tribData = ~tribData;
    fullCycle();

    // Directed: group 2 in three-lane mode with alarm and failure on spare lane (R7)
    groupDs1 = 7'b1111011;
    aisEn    = NCH'(1) << 11;
    groupFail = 7'b0000100;
    tribData = '0;
    fullCycle();
    // spare lane reappears with its loaded value once group returns to four lanes (R8)
    @(negedge clk) groupDs1 = '1;
    @(negedge clk) checkLanes();
    aisEn = '0;
    groupFail = '0;

    // Directed: failure confined to group 3 (R5)
    groupFail = 7'b0001000;
    tribData  = '0;
    fullCycle();
    groupFail = '0;

    // Directed: top-level failure (R6), all lanes rising then all falling
    globalFail = 1'b1;
    edgeRise   = '1;
    fullCycle();
    globalFail = 1'b0;
    edgeRise   = '0;
    fullCycle();

    // Random mixture
    for (int it = 0; it < 60; it++) begin
      @(negedge clk);
      tribData   = NCH'($urandom);
      aisEn      = NCH'($urandom & $urandom & $urandom);
      edgeRise   = NCH'($urandom);
      groupDs1   = NG'($urandom);
      groupFail  = ($urandom % 4 == 0) ? NG'(1 << ($urandom % NG)) : '0;
      globalFail = ($urandom % 10 == 0);
      chanSel    = {$urandom, $urandom} & {NCH*SELW{1'b1}};
      fullCycle();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule